// File: doc/BRIEF.md
# Affine Warp Address Expander

This block turns a compressed affine memory operand into the per-lane addresses of a 32-lane warp. The operand arrives as a base address and a per-lane stride. With it comes an active mask that says which lanes take part. Lane i addresses `base + stride * i`, so an operand indexed by thread number with 4-byte elements has a stride of 4. The addresses are not gathered as 32 independent values. The block generates them itself and sends them out in beats of 8 lanes over 4 consecutive cycles.

Alongside the addresses, the block reports a coalescing summary. The memory space is split into aligned 128-byte segments. The block counts how many segment changes the active lanes make when taken in lane order. It also flags the case where every active access lands in a single segment, which means one request serves the whole warp. The count comes from the base and the stride alone, lane by lane. It needs no pairwise comparison of addresses. Inactive lanes produce no address and do not enter the count.

Top module: `affine_addr_expander`

## Requirements
- R1: After reset, `busy_o`, `addr_valid_o` and `done_o` are 0, and `seg_count_o` and `coalesced_o` are 0.
- R2: A `start_i` seen high at a clock edge while `busy_o` is low is accepted. In the 4 cycles that follow, `addr_valid_o` is 1 and `beat_o` takes the values 0, 1, 2 and 3 in turn. In the cycle after beat 3, `addr_valid_o` is 0.
- R3: In beat k, element j of `addr_o` (bits `32*j+31 : 32*j`) carries lane `8*k+j`. For an active lane its value is `base + stride * lane`, taken modulo 2^32.
- R4: `lane_mask_o` bit j in beat k equals the captured active-mask bit of lane `8*k+j`. The element of `addr_o` for an inactive lane is 0.
- R5: `done_o` is 1 exactly in the cycle that carries beat 3.
- R6: `seg_count_o` gives the number of active lanes, taken in ascending lane order, whose segment number `addr >> 7` is either the first one seen or differs from the segment of the previous active lane. It is valid from the beat 0 cycle and is held until the next accepted start.
- R7: `coalesced_o` is 1 exactly when `seg_count_o` is 1.
- R8: A stride of 0 with at least one active lane gives `seg_count_o` = 1 and `coalesced_o` = 1.
- R9: A `start_i` that arrives while `busy_o` is high is ignored. The beats in flight keep their captured operands, and the summary does not change.
- R10: An all-zero active mask still produces the 4 beats. In every beat `lane_mask_o` is 0 and all addresses are 0, and the summary is `seg_count_o` = 0 and `coalesced_o` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Request to expand the operand presented this cycle |
| base_i | input | 32 | Address of lane 0 |
| stride_i | input | 32 | Byte distance between neighbouring lanes (modulo 2^32) |
| active_i | input | 32 | Active mask, bit i for lane i |
| busy_o | output | 1 | Expansion in progress |
| addr_valid_o | output | 1 | `addr_o` and `lane_mask_o` hold a beat |
| beat_o | output | 2 | Index of the current beat |
| addr_o | output | 256 | Eight lane addresses of the current beat |
| lane_mask_o | output | 8 | Active bits of the eight lanes in the beat |
| done_o | output | 1 | Current beat is the last one |
| seg_count_o | output | 6 | Number of segment changes across the active lanes |
| coalesced_o | output | 1 | All active lanes fall in one segment |

## Verification
A start is accepted at a clock edge. Beat k then appears in the k+1-th cycle after that edge, the summary appears together with beat 0, and `addr_valid_o` drops one cycle after beat 3. Each scenario drives its inputs at a falling edge and then samples at each falling edge that follows. So every beat, the done pulse and the summary are read in the exact cycle the timing above assigns to them. Some of the data is rejected or ignored: starts issued during an expansion, and inactive lanes. These are checked through the beat contents and the held summary before the next accepted start.

// File: rtl/aae_pkg.sv
package aae_pkg;
    localparam int unsigned WARP_LANES = 32;
    localparam int unsigned BEAT_LANES = 8;
    localparam int unsigned ADDR_WIDTH = 32;
    localparam int unsigned SEG_BYTES  = 128;

    // address of one lane of an affine operand
    function automatic logic [ADDR_WIDTH-1:0] lane_addr(
        input logic [ADDR_WIDTH-1:0] base,
        input logic [ADDR_WIDTH-1:0] stride,
        input logic [ADDR_WIDTH-1:0] lane
    );
        return base + stride * lane;
    endfunction
endpackage

// File: rtl/aae_seg_summary.sv
module aae_seg_summary
    import aae_pkg::*;
#(
    parameter int unsigned LANES     = WARP_LANES,
    parameter int unsigned ADDR_W    = ADDR_WIDTH,
    parameter int unsigned SEG_B     = SEG_BYTES,
    localparam int unsigned SEG_SH   = $clog2(SEG_B),
    localparam int unsigned CNT_W    = $clog2(LANES + 1)
) (
    input  logic [ADDR_W-1:0] base_i,
    input  logic [ADDR_W-1:0] stride_i,
    input  logic [LANES-1:0]  active_i,
    output logic [CNT_W-1:0]  seg_count_o
);
    logic [ADDR_W-1:0]        cur_addr;
    logic [ADDR_W-SEG_SH-1:0] cur_seg;
    logic [ADDR_W-SEG_SH-1:0] prev_seg;
    logic                     seen;
    logic [CNT_W-1:0]         cnt;

    // walk the lanes in order; a new segment is counted on each change
    always_comb begin
        cur_addr = '0;
        cur_seg  = '0;
        prev_seg = '0;
        seen     = 1'b0;
        cnt      = '0;
        for (int i = 0; i < int'(LANES); i++) begin
            cur_addr = base_i + stride_i * ADDR_W'(i);
            cur_seg  = cur_addr[ADDR_W-1:SEG_SH];
            if (active_i[i]) begin
                if (!seen || (cur_seg != prev_seg)) begin
                    cnt = cnt + CNT_W'(1);
                end
                prev_seg = cur_seg;
                seen     = 1'b1;
            end
        end
    end

    assign seg_count_o = cnt;
endmodule

// File: rtl/aae_beat_lanes.sv
module aae_beat_lanes
    import aae_pkg::*;
#(
    parameter int unsigned BLANES  = BEAT_LANES,
    parameter int unsigned ADDR_W  = ADDR_WIDTH,
    parameter int unsigned BEAT_W  = 2
) (
    input  logic [ADDR_W-1:0]        base_i,
    input  logic [ADDR_W-1:0]        stride_i,
    input  logic [BEAT_W-1:0]        beat_i,
    input  logic [BLANES-1:0]        mask_i,
    output logic [BLANES*ADDR_W-1:0] addr_o
);
    logic [ADDR_W-1:0] first_lane;

    assign first_lane = ADDR_W'(beat_i) * ADDR_W'(BLANES);

    for (genvar j = 0; j < int'(BLANES); j++) begin : g_lane
        logic [ADDR_W-1:0] lane_idx;
        assign lane_idx = first_lane + ADDR_W'(j);
        assign addr_o[j*ADDR_W +: ADDR_W] =
            mask_i[j] ? lane_addr(base_i, stride_i, lane_idx) : '0;
    end
endmodule

// File: rtl/affine_addr_expander.sv
module affine_addr_expander
    import aae_pkg::*;
#(
    parameter int unsigned LANES    = WARP_LANES,
    parameter int unsigned BLANES   = BEAT_LANES,
    parameter int unsigned ADDR_W   = ADDR_WIDTH,
    parameter int unsigned SEG_B    = SEG_BYTES,
    localparam int unsigned BEATS   = LANES / BLANES,
    localparam int unsigned BEAT_W  = (BEATS > 1) ? $clog2(BEATS) : 1,
    localparam int unsigned CNT_W   = $clog2(LANES + 1)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     start_i,
    input  logic [ADDR_W-1:0]        base_i,
    input  logic [ADDR_W-1:0]        stride_i,
    input  logic [LANES-1:0]         active_i,
    output logic                     busy_o,
    output logic                     addr_valid_o,
    output logic [BEAT_W-1:0]        beat_o,
    output logic [BLANES*ADDR_W-1:0] addr_o,
    output logic [BLANES-1:0]        lane_mask_o,
    output logic                     done_o,
    output logic [CNT_W-1:0]         seg_count_o,
    output logic                     coalesced_o
);
    localparam logic [BEAT_W-1:0] LAST_BEAT = BEAT_W'(BEATS - 1);

    typedef struct packed {
        logic              busy;
        logic [BEAT_W-1:0] beat;
        logic [ADDR_W-1:0] base;
        logic [ADDR_W-1:0] stride;
        logic [LANES-1:0]  mask;
        logic [CNT_W-1:0]  segs;
        logic              coal;
    } state_t;

    state_t           st_d, st_q;
    logic [CNT_W-1:0] seg_cnt;
    logic [BLANES-1:0] beat_mask;

    aae_seg_summary #(
        .LANES (LANES),
        .ADDR_W(ADDR_W),
        .SEG_B (SEG_B)
    ) u_summary (
        .base_i     (base_i),
        .stride_i   (stride_i),
        .active_i   (active_i),
        .seg_count_o(seg_cnt)
    );

    always_comb begin
        st_d = st_q;
        if (!st_q.busy) begin
            if (start_i) begin
                st_d.busy   = 1'b1;
                st_d.beat   = '0;
                st_d.base   = base_i;
                st_d.stride = stride_i;
                st_d.mask   = active_i;
                st_d.segs   = seg_cnt;
                st_d.coal   = (seg_cnt == CNT_W'(1));
            end
        end else if (st_q.beat == LAST_BEAT) begin
            st_d.busy = 1'b0;
            st_d.beat = '0;
        end else begin
            st_d.beat = st_q.beat + BEAT_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign beat_mask = st_q.mask[int'(st_q.beat) * int'(BLANES) +: BLANES];

    aae_beat_lanes #(
        .BLANES(BLANES),
        .ADDR_W(ADDR_W),
        .BEAT_W(BEAT_W)
    ) u_lanes (
        .base_i  (st_q.base),
        .stride_i(st_q.stride),
        .beat_i  (st_q.beat),
        .mask_i  (beat_mask),
        .addr_o  (addr_o)
    );

    assign busy_o       = st_q.busy;
    assign addr_valid_o = st_q.busy;
    assign beat_o       = st_q.beat;
    assign lane_mask_o  = st_q.busy ? beat_mask : '0;
    assign done_o       = st_q.busy && (st_q.beat == LAST_BEAT);
    assign seg_count_o  = st_q.segs;
    assign coalesced_o  = st_q.coal;

    // R2: an accepted start opens beat 0 on the next cycle
    p_start_beat0_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !busy_o) |=> (addr_valid_o && beat_o == '0));

    // R2: beats advance by one without gaps
    p_beat_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (addr_valid_o && beat_o != LAST_BEAT) |=>
            (addr_valid_o && beat_o == $past(beat_o) + BEAT_W'(1)));

    // R5: done only with the final beat
    p_done_last_r5: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (addr_valid_o && beat_o == LAST_BEAT));

    // R7: coalesced flag implies a single segment
    p_coal_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
        coalesced_o |-> (seg_count_o == CNT_W'(1)));

    // R8: a zero stride with any active lane is one segment
    p_bcast_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !busy_o && stride_i == '0 && active_i != '0) |=>
            (seg_count_o == CNT_W'(1) && coalesced_o));

    // R9: summary does not move while an expansion runs
    p_hold_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |=> ($stable(seg_count_o) && $stable(coalesced_o)));

    // R10: an empty mask gives an empty summary
    p_empty_mask_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !busy_o && active_i == '0) |=>
            (seg_count_o == '0 && !coalesced_o));
endmodule

// File: tb/affine_addr_expander_tb.sv
`timescale 1ns/1ps
module affine_addr_expander_tb_top;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start_i = 1'b0;
    logic [31:0]  base_i = '0;
    logic [31:0]  stride_i = '0;
    logic [31:0]  active_i = '0;
    logic         busy_o, addr_valid_o, done_o, coalesced_o;
    logic [1:0]   beat_o;
    logic [255:0] addr_o;
    logic [7:0]   lane_mask_o;
    logic [5:0]   seg_count_o;

    int n_checks = 0;
    int n_errors = 0;
    int cyc = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    affine_addr_expander dut_i (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .base_i(base_i),
        .stride_i(stride_i), .active_i(active_i), .busy_o(busy_o),
        .addr_valid_o(addr_valid_o), .beat_o(beat_o), .addr_o(addr_o),
        .lane_mask_o(lane_mask_o), .done_o(done_o),
        .seg_count_o(seg_count_o), .coalesced_o(coalesced_o)
    );

    task automatic chk(input string what, input logic [255:0] act, input logic [255:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: actual=%0h expected=%0h", what, act, exp);
        end
    endtask

    function automatic int model_segs(input logic [31:0] b, input logic [31:0] s,
                                      input logic [31:0] m);
        int cnt = 0;
        bit seen = 0;
        logic [24:0] prev = '0;
        for (int i = 0; i < 32; i++) begin
            logic [31:0] a = b + s * i;
            if (m[i]) begin
                if (!seen || a[31:7] != prev) cnt++;
                prev = a[31:7];
                seen = 1;
            end
        end
        return cnt;
    endfunction

    function automatic logic [255:0] model_beat(input logic [31:0] b, input logic [31:0] s,
                                                input logic [31:0] m, input int k);
        logic [255:0] v = '0;
        for (int j = 0; j < 8; j++) begin
            int lane = k * 8 + j;
            if (m[lane]) v[j*32 +: 32] = b + s * lane;
        end
        return v;
    endfunction

    // check the 4 beats of an accepted operation; starts at the negedge after acceptance
    task automatic check_beats(input string tag, input logic [31:0] b, input logic [31:0] s,
                               input logic [31:0] m, input int exp_segs);
        for (int k = 0; k < 4; k++) begin
            chk({tag, " R2 valid"}, 256'(addr_valid_o), 256'(1));
            chk({tag, " R2 beat"}, 256'(beat_o), 256'(k));
            chk({tag, " R5 done"}, 256'(done_o), 256'(k == 3));
            chk({tag, " R4 mask"}, 256'(lane_mask_o), 256'(m[k*8 +: 8]));
            chk({tag, " R3 addr"}, addr_o, model_beat(b, s, m, k));
            chk({tag, " R6 segs"}, 256'(seg_count_o), 256'(exp_segs));
            chk({tag, " R7 coal"}, 256'(coalesced_o), 256'(exp_segs == 1));
            @(negedge clk);
        end
        chk({tag, " R2 idle after"}, 256'(addr_valid_o), 256'(0));
        chk({tag, " R6 held"}, 256'(seg_count_o), 256'(exp_segs));
    endtask

    task automatic run_op(input string tag, input logic [31:0] b, input logic [31:0] s,
                          input logic [31:0] m, input int exp_segs);
        int ms;
        ms = model_segs(b, s, m);
        chk({tag, " R6 model"}, 256'(ms), 256'(exp_segs));
        @(negedge clk);
        start_i = 1'b1; base_i = b; stride_i = s; active_i = m;
        @(negedge clk);
        start_i = 1'b0; base_i = '0; stride_i = '0; active_i = '0;
        check_beats(tag, b, s, m, exp_segs);
    endtask

    task automatic test_reset();
        chk("R1 busy", 256'(busy_o), 256'(0));
        chk("R1 valid", 256'(addr_valid_o), 256'(0));
        chk("R1 done", 256'(done_o), 256'(0));
        chk("R1 segs", 256'(seg_count_o), 256'(0));
        chk("R1 coal", 256'(coalesced_o), 256'(0));
    endtask

    task automatic test_busy_ignore();
        logic [31:0] b = 32'h0000_5000;
        logic [31:0] s = 32'd4;
        @(negedge clk);
        start_i = 1'b1; base_i = b; stride_i = s; active_i = '1;
        @(negedge clk);
        // beat 0 visible; offer a second start at beats 0..3 (R9)
        start_i = 1'b1; base_i = 32'h0000_9040; stride_i = 32'd128; active_i = 32'h0F0F_0F0F;
        for (int k = 0; k < 4; k++) begin
            chk("R9 beat", 256'(beat_o), 256'(k));
            chk("R9 addr kept", addr_o, model_beat(b, s, '1, k));
            chk("R9 segs kept", 256'(seg_count_o), 256'(1));
            @(negedge clk);
        end
        start_i = 1'b0; base_i = '0; stride_i = '0; active_i = '0;
        // the start seen during the done beat was not taken either
        chk("R9 not accepted", 256'(addr_valid_o), 256'(0));
        chk("R9 summary kept", 256'(seg_count_o), 256'(1));
        chk("R9 coal kept", 256'(coalesced_o), 256'(1));
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000 && !finished) begin
            finished = 1'b1;
            n_errors++;
            n_checks++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        test_reset();
        rst_n = 1'b1;
        @(negedge clk);
        test_reset();
        run_op("unit stride aligned R6", 32'h0000_1000, 32'd4, 32'hFFFF_FFFF, 1);
        run_op("unit stride straddle R6", 32'h0000_1040, 32'd4, 32'hFFFF_FFFF, 2);
        run_op("segment stride R6", 32'h0000_0000, 32'd128, 32'hFFFF_FFFF, 32);
        run_op("broadcast R8", 32'h0000_2234, 32'd0, 32'h00F0_0F01, 1);
        run_op("empty mask R10", 32'h0000_4000, 32'd4, 32'h0000_0000, 0);
        run_op("upper half R4", 32'h0000_3000, 32'd8, 32'hFFFF_0000, 1);
        run_op("descending R3", 32'h0000_1000, 32'hFFFF_FFFC, 32'hFFFF_FFFF, 2);
        run_op("sparse wide R4", 32'hFFFF_FFC0, 32'd64, 32'h8000_0011, 3);
        test_busy_ignore();
        if (!finished) begin
            finished = 1'b1;
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end
endmodule